// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Bank

This block drives several pulse-width-modulated outputs from one register port. Each channel owns a single 32-bit control word that holds a run bit, an 8-bit high-time value and a 13-bit clock divider. While a channel runs, its prescaler produces one tick every `divider + 1` input clocks, and an 8-bit phase counter advances on each tick. A full period is always 256 ticks. The output is high while the phase is below the high-time value, so the high part of each period comes first.

Software writes a control word with a strobe and an address, and reads any control word back through a combinational read port. Control words sit 16 bytes apart, so the address bits above bit 3 select the channel. When a channel is already running, new high-time and divider values are held until the current period ends, which keeps a half-finished pulse from being cut or stretched. When a write sets the run bit of a stopped channel, that channel starts again at phase zero with the new values.

Top module: `pwm_bank`

## Requirements
- R1: The control word carries the run bit at bit 31, the high-time value at bits 23:16 and the divider at bits 12:0. A read returns the last value written with bits 30:24 and 15:13 forced to zero.
- R2: While a channel's run bit is clear, its output stays low whatever its high-time value.
- R3: A running channel is high for exactly `duty` ticks of every 256-tick period, and those ticks come first in the period.
- R4: One tick lasts `divider + 1` input clocks, so one period lasts 256 × (divider + 1) clocks.
- R5: A high-time value of 0 keeps the output low for the whole period. A value of 255 gives 255 high ticks out of 256.
- R6: A write that changes the high-time or divider of a running channel takes effect only from the next period boundary. The rest of the current period uses the old values.
- R7: A write that sets the run bit of a stopped channel restarts it at phase zero with the written values. In the first clock after that write, the output is high exactly when the written high-time is nonzero.
- R8: Writing zero to a control word reads back as zero and leaves that output low.
- R9: The channel index is `reg_addr[ADDR_W-1:4]`. Bits 3:0 are ignored. An index of NUM_CH or more reads as zero, and a write to it changes no channel.
- R10: Channels run independently, each with its own high-time and divider.
- R11: A synchronous active-low reset clears every control word, every counter and every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the control word |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control word at `reg_addr` (combinational) |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench builds the block with NUM_CH = 3 and ADDR_W = 6. This leaves one spare address slot, index 3, so the out-of-range read and write rules of the decode can be tested. The divider values used in the runs are small (0 to 3), which keeps a full period between 256 and 1024 clocks. That makes it practical to count high cycles over whole periods, over the head of a period and over the rest of a period that is interrupted by a write. The full 13-bit divider field is checked only through readback.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
// pwm_bank_pkg: control-word layout and per-channel configuration type.
// Assumes a 32-bit register port; the field positions are fixed by the layout.
package pwm_bank_pkg;
    localparam int REG_W       = 32;
    localparam int EN_POS      = 31;
    localparam int DUTY_LSB    = 16;
    localparam int DUTY_W      = 8;
    localparam int DIV_LSB     = 0;
    localparam int DIV_W       = 13;
    localparam int SLOT_BITS   = 4;   // 16-byte spacing between channels
    localparam int PHASE_MAX   = (1 << DUTY_W) - 1;

    typedef struct packed {
        logic              en;
        logic [DUTY_W-1:0] duty;
        logic [DIV_W-1:0]  div;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
// pwm_prescaler: produces a one-clock tick every (limit+1) clocks while run is high.
// Assumes limit changes only when the count is restarted (idle or at tick).
module pwm_prescaler #(
    parameter int LIM_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             tick
);
    logic [LIM_W-1:0] cnt_q;

    assign tick = run && (cnt_q == limit);

    // Count clocks up to the limit and restart; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// pwm_channel: one control word, the shadow values it applies, the phase
// counter and the comparator. Assumes wr_sel is a one-cycle write strobe.
// New high-time and divider values reach the shadow at a period wrap, or
// at once while the channel is stopped, so enabling restarts at phase 0.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_word,
    output logic             en,
    output logic             pwm
);
    ch_cfg_t           cfg_q;
    ch_cfg_t           cfg_new;
    logic [DUTY_W-1:0] duty_act_q;
    logic [DIV_W-1:0]  div_act_q;
    logic [DUTY_W-1:0] phase_q;
    logic              tick;
    logic              wrap;
    logic              idle;
    logic              unused_rsv;

    assign cfg_new.en   = wdata[EN_POS];
    assign cfg_new.duty = wdata[DUTY_LSB +: DUTY_W];
    assign cfg_new.div  = wdata[DIV_LSB +: DIV_W];
    assign unused_rsv   = ^{wdata[EN_POS-1:DUTY_LSB+DUTY_W], wdata[DUTY_LSB-1:DIV_LSB+DIV_W]};

    assign idle = !cfg_q.en;
    assign en   = cfg_q.en;
    assign wrap = tick && (phase_q == DUTY_W'(PHASE_MAX));

    // Hold the programmed control word; reserved bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_sel) begin
            cfg_q <= cfg_new;
        end
    end

    // Rebuild the 32-bit readback word with reserved bits at zero.
    always_comb begin
        cfg_word = '0;
        cfg_word[EN_POS]              = cfg_q.en;
        cfg_word[DUTY_LSB +: DUTY_W]  = cfg_q.duty;
        cfg_word[DIV_LSB +: DIV_W]    = cfg_q.div;
    end

    // Load the applied values while stopped, or at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_act_q <= '0;
            div_act_q  <= '0;
        end else if (idle) begin
            duty_act_q <= wr_sel ? cfg_new.duty : cfg_q.duty;
            div_act_q  <= wr_sel ? cfg_new.div  : cfg_q.div;
        end else if (wrap) begin
            duty_act_q <= cfg_q.duty;
            div_act_q  <= cfg_q.div;
        end
    end

    pwm_prescaler #(.LIM_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_q.en),
        .limit (div_act_q),
        .tick  (tick)
    );

    // Advance the phase once per tick; park at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || idle) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign pwm = cfg_q.en && (phase_q < duty_act_q);
endmodule

// File: rtl/pwm_bank_decode.sv
`timescale 1ns/1ps
// pwm_bank_decode: turns the slot index into per-channel write selects and
// picks the readback word. Assumes NUM_CH <= 2**IDX_W; unused slots read zero.
module pwm_bank_decode
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0]             slot_idx,
    input  logic                         wr,
    input  logic [NUM_CH-1:0][REG_W-1:0] cfg_words,
    output logic [NUM_CH-1:0]            wr_sel,
    output logic [REG_W-1:0]             rdata
);
    // One write select per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        assign wr_sel[i] = wr && (slot_idx == IDX_W'(i));
    end

    // Return the addressed word, or zero for a slot without a channel.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (slot_idx == IDX_W'(i)) begin
                rdata = cfg_words[i];
            end
        end
    end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
// pwm_bank: register-programmed bank of NUM_CH PWM channels.
// Assumes one register access per cycle; reads are combinational.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int IDX_W = ADDR_W - SLOT_BITS;

    logic [NUM_CH-1:0][REG_W-1:0] cfg_words;
    logic [NUM_CH-1:0]            wr_sel;
    logic [NUM_CH-1:0]            ch_en;
    logic                         unused_addr_low;

    assign unused_addr_low = ^reg_addr[SLOT_BITS-1:0];

    pwm_bank_decode #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_dec (
        .slot_idx  (reg_addr[ADDR_W-1:SLOT_BITS]),
        .wr        (reg_wr),
        .cfg_words (cfg_words),
        .wr_sel    (wr_sel),
        .rdata     (reg_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (wr_sel[i]),
            .wdata    (reg_wdata),
            .cfg_word (cfg_words[i]),
            .en       (ch_en[i]),
            .pwm      (pwm_out[i])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
// pwm_bank_chk: temporal checks on pwm_bank, attached by bind.
module pwm_bank_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] ch_en
);
    localparam int IDX_W = ADDR_W - 4;

    // R1: reserved bits never show up on readback
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[30:24] == 7'd0) && (reg_rdata[15:13] == 3'd0));

    // R9: slots without a channel read zero
    a_r9_empty_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(reg_addr[ADDR_W-1:4]) >= NUM_CH) |-> (reg_rdata == 32'd0));

    // R11: outputs are low in the first cycle after reset
    a_r11_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pwm_out == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit = reg_wr && (reg_addr[ADDR_W-1:4] == IDX_W'(i));

        // R2: a write with the run bit clear leaves the output low
        a_r2_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && hit && !reg_wdata[31]) |-> !pwm_out[i]);

        // R7: starting a stopped channel begins at phase zero
        a_r7_restart_phase0: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n && hit && reg_wdata[31] && !ch_en[i])
            |-> (pwm_out[i] == ($past(reg_wdata[23:16]) != 8'd0)));
    end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pwm_out   (pwm_out),
    .ch_en     (ch_en)
);

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
    localparam int NCH = 3;
    localparam int AW  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic           reg_wr = 1'b0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        int    ch;
        int    len;
        int    exp_hi;
        string tag;
    } win_t;
    win_t win_q[$];

    always #4 clk = ~clk;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(AW)) u_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    // Monitor: pop an expected window, count high cycles, compare at its end.
    initial begin
        win_t cur;
        bit   active = 0;
        int   left = 0;
        int   hi = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!active && win_q.size() > 0) begin
                cur = win_q.pop_front();
                active = 1;
                left = cur.len;
                hi = 0;
            end
            if (active) begin
                hi += int'(pwm_out[cur.ch]);
                left--;
                if (left == 0) begin
                    active = 0;
                    n_checks++;
                    if (hi != cur.exp_hi) begin
                        n_fail++;
                        $display("FAIL %s: ch%0d high cycles %0d expected %0d",
                                 cur.tag, cur.ch, hi, cur.exp_hi);
                    end
                end
            end
        end
    end

    // Driver: one register write; returns at the negedge after the capturing edge.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Driver: queue an expected high count over the next len cycles.
    task automatic expect_win(input int ch, input int len, input int exp_hi, input string tag);
        win_t w;
        w.ch = ch; w.len = len; w.exp_hi = exp_hi; w.tag = tag;
        win_q.push_back(w);
        repeat (len) @(negedge clk);
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_checks++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: read 0x%0h got 0x%08h expected 0x%08h", tag, a, reg_rdata, exp);
        end
        @(negedge clk);
    endtask

    task automatic out_check(input logic [NCH-1:0] exp, input string tag);
        n_checks++;
        if (pwm_out !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_out %b expected %b", tag, pwm_out, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1-watchdog: cycles %0d expected below %0d", 200000, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        rd_check(6'h00, 32'h0, "R11");
        rd_check(6'h10, 32'h0, "R11");
        rd_check(6'h20, 32'h0, "R11");
        out_check('0, "R11");

        // R1: field layout and reserved bits
        wr(6'h20, 32'hFFFF_FFFF);
        rd_check(6'h20, 32'h80FF_1FFF, "R1");
        // R8: writing zero clears
        wr(6'h20, 32'h0);
        rd_check(6'h20, 32'h0, "R8");
        expect_win(2, 50, 0, "R8");

        // R9: decode of slot index
        wr(6'h14, 32'h0003_0005);
        rd_check(6'h10, 32'h0003_0005, "R9");
        rd_check(6'h1C, 32'h0003_0005, "R9");
        wr(6'h30, 32'h80FF_0000);
        rd_check(6'h30, 32'h0, "R9");
        rd_check(6'h00, 32'h0, "R9");
        rd_check(6'h20, 32'h0, "R9");
        rd_check(6'h10, 32'h0003_0005, "R9");

        // R2: stopped channel with nonzero duty stays low
        expect_win(1, 100, 0, "R2");

        // R3: duty 10, divider 1 -> high first 20 clocks of 512
        wr(6'h00, 32'h800A_0001);
        expect_win(0, 20, 20, "R3");
        expect_win(0, 492, 0, "R3");
        expect_win(0, 512, 20, "R4");

        // R4: duty 64, divider 2 -> 192 high then 576 low
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h8040_0002);
        expect_win(0, 192, 192, "R4");
        expect_win(0, 576, 0, "R4");

        // R5: duty extremes
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h80FF_0000);
        expect_win(0, 256, 255, "R5");
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h8000_0000);
        expect_win(0, 512, 0, "R5");

        // R6: update mid-period waits for the wrap
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h8020_0000);
        expect_win(0, 100, 32, "R6");
        wr(6'h00, 32'h80C8_0000);
        expect_win(0, 154, 0, "R6");
        expect_win(0, 256, 200, "R6");
        wr(6'h00, 32'h80C8_0001);
        expect_win(0, 254, 198, "R6");
        expect_win(0, 512, 400, "R6");

        // R7: stop then start restarts at phase zero
        wr(6'h00, 32'h0);
        wr(6'h00, 32'h800A_0000);
        expect_win(0, 10, 10, "R7");
        expect_win(0, 246, 0, "R7");

        // R10: independent channels
        wr(6'h10, 32'h8080_0000);
        wr(6'h20, 32'h8010_0003);
        expect_win(1, 256, 128, "R10");
        expect_win(2, 1024, 64, "R10");
        expect_win(0, 256, 10, "R10");
        rd_check(6'h20, 32'h8010_0003, "R10");

        // R8: clearing a running channel
        wr(6'h10, 32'h0);
        rd_check(6'h10, 32'h0, "R8");
        expect_win(1, 300, 0, "R8");

        // R11: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        out_check('0, "R11");
        rd_check(6'h00, 32'h0, "R11");
        rd_check(6'h20, 32'h0, "R11");
        expect_win(2, 50, 0, "R11");
        expect_win(0, 50, 0, "R11");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule